// File: doc/BRIEF.md
# Continuous Sample-Point Tracker

This block keeps the sampling delay tap of one received bit centred in its data eye while ordinary traffic flows, once the initial alignment has finished. Each received bit is captured twice: a primary sampler whose delay tap (`master_tap`) feeds the data path, and a secondary sampler whose tap (`slave_tap`) is free to move. The tracker parks the secondary sampler a fixed number of taps above the primary one and compares the two captured words over a test window. It then parks it the same distance below and compares again. When exactly one side disagrees with the primary sampler, the eye has drifted toward that side, and the primary tap is moved one step the other way.

Moving a delay tap that feeds live data can corrupt the samples taken while it settles. The tracker therefore hands the data path to the secondary sampler first: it sets the secondary tap equal to the primary one, switches the output select to the secondary, steps the primary tap, waits, and switches back. No training pattern is needed. Any traffic whose bits toggle exposes a drifting eye edge, and the rounds repeat for as long as tracking is allowed.

The tap loaded from the initial alignment arrives on `init_tap` and is taken while `align_done` is low. Tracking runs only while both `align_done` and `track_en` are high, and `halt` freezes it in place.

Top module: `sample_point_tracker`

## Requirements
- R1: While `align_done` is low, `master_tap` follows `init_tap`. Whenever `align_done` or `track_en` is low, `slave_tap` equals `master_tap`, `out_sel` is 0 and no tracking happens. While `align_done` is high and `track_en` is low, `master_tap` holds its value and ignores `init_tap`.
- R2: Each tracking round first places `slave_tap` at the upper probe for SETTLE+TEST_LEN cycles. It then places it at the lower probe for SETTLE+TEST_LEN cycles, followed by one decision cycle. The upper probe is `master_tap`+PROBE_OFS and the lower probe is `master_tap`-PROBE_OFS, subject to R7. In each probe dwell only the last TEST_LEN cycles are compared; the first SETTLE cycles are skipped.
- R3: A probe side fails when, in any compared cycle, `slave_word` differs from `master_word` in any bit. Ordinary toggling data is enough to drive this; no special pattern is required.
- R4: When both sides pass, or both sides fail, `master_tap` is left unchanged.
- R5: A tap change runs as a hand-off. `slave_tap` is set to `master_tap`, and SETTLE cycles later `out_sel` goes to 1 (1 means the secondary sampler drives the data path, 0 the primary). One cycle later `master_tap` steps. SETTLE cycles after that, `out_sel` returns to 0. `master_tap` never changes during tracking unless `out_sel` is 1.
- R6: When only the upper side fails, `master_tap` decreases by one. When only the lower side fails, it increases by one. A tracking step is always exactly one tap.
- R7: `master_tap` stays in 0..MAX_TAP. A step below 0 or above MAX_TAP is dropped. A probe that would fall outside the range is clamped to 0 or MAX_TAP.
- R8: While `halt` is high (with tracking enabled), `master_tap`, `slave_tap` and `out_sel` hold their values. Tracking resumes where it stopped once `halt` falls.
- R9: A round without a move repeats every 2*(SETTLE+TEST_LEN)+1 cycles. A round with a move takes 2*SETTLE+1 further cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the deserialised word domain |
| rst_n | input | 1 | Active-low synchronous reset |
| track_en | input | 1 | Continuous tracking allowed |
| halt | input | 1 | Freeze tracking while high |
| align_done | input | 1 | Initial alignment complete |
| init_tap | input | TAP_W | Tap chosen by initial alignment |
| master_word | input | WORD_W | Word captured by the primary sampler |
| slave_word | input | WORD_W | Word captured by the secondary sampler |
| master_tap | output | TAP_W | Delay tap of the primary sampler |
| slave_tap | output | TAP_W | Delay tap of the secondary sampler |
| out_sel | output | 1 | Data path source: 0 primary, 1 secondary |

## Verification
A step decision and the glitch-free hand-off meet in one cycle: the primary tap moves in the cycle where the output select is already on the secondary sampler. A bench monitor judges every tap change against the select and the previous tap value. Freeze and decision also collide: `halt` is raised before tracking opens on an eye that would force a move, and the bench checks that no tap moves until `halt` falls. It then checks that the expected move follows. A sweep of every start tap against a modelled eye, including both range ends and an eye whose two probes both fail, compares the final tap with a round-by-round arithmetic model.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE_HI,
        ST_PROBE_LO,
        ST_DECIDE,
        ST_ALIGN,
        ST_STEP,
        ST_HOLD
    } spt_state_e;

endpackage

// File: rtl/spt_probe_calc.sv
module spt_probe_calc #(
    parameter int TAP_W     = 5,
    parameter int MAX_TAP   = 31,
    parameter int PROBE_OFS = 2
) (
    input  logic [TAP_W-1:0] center,
    output logic [TAP_W-1:0] probe_hi,
    output logic [TAP_W-1:0] probe_lo
);
    localparam logic [TAP_W:0] OFS_W = (TAP_W+1)'(PROBE_OFS);
    localparam logic [TAP_W:0] MAX_W = (TAP_W+1)'(MAX_TAP);

    logic [TAP_W:0] wide_c;
    logic [TAP_W:0] sum_w;

    always_comb begin
        wide_c = {1'b0, center};
        sum_w  = wide_c + OFS_W;
        if (sum_w > MAX_W) begin
            probe_hi = MAX_W[TAP_W-1:0];
        end else begin
            probe_hi = sum_w[TAP_W-1:0];
        end
        if (wide_c < OFS_W) begin
            probe_lo = '0;
        end else begin
            probe_lo = center - OFS_W[TAP_W-1:0];
        end
    end
endmodule

// File: rtl/spt_word_cmp.sv
module spt_word_cmp #(
    parameter int WORD_W = 4
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output logic              differ
);
    logic [WORD_W-1:0] bit_diff;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign bit_diff[i] = word_a[i] ^ word_b[i];
    end

    assign differ = |bit_diff;
endmodule

// File: rtl/spt_step_decide.sv
module spt_step_decide #(
    parameter int TAP_W   = 5,
    parameter int MAX_TAP = 31
) (
    input  logic [TAP_W-1:0] center,
    input  logic             hi_bad,
    input  logic             lo_bad,
    output logic             move,
    output logic [TAP_W-1:0] next_tap
);
    localparam logic [TAP_W-1:0] MAX_T = TAP_W'(MAX_TAP);

    always_comb begin
        move     = 1'b0;
        next_tap = center;
        if (lo_bad && !hi_bad && center < MAX_T) begin
            move     = 1'b1;
            next_tap = center + 1'b1;
        end else if (hi_bad && !lo_bad && center != '0) begin
            move     = 1'b1;
            next_tap = center - 1'b1;
        end
    end
endmodule

// File: rtl/sample_point_tracker.sv
module sample_point_tracker
    import spt_pkg::*;
#(
    parameter int WORD_W    = 4,
    parameter int TAP_W     = 5,
    parameter int MAX_TAP   = 31,
    parameter int PROBE_OFS = 2,
    parameter int TEST_LEN  = 128,
    parameter int SETTLE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_en,
    input  logic              halt,
    input  logic              align_done,
    input  logic [TAP_W-1:0]  init_tap,
    input  logic [WORD_W-1:0] master_word,
    input  logic [WORD_W-1:0] slave_word,
    output logic [TAP_W-1:0]  master_tap,
    output logic [TAP_W-1:0]  slave_tap,
    output logic              out_sel
);
    localparam int DWELL = SETTLE + TEST_LEN;
    localparam int CNT_W = $clog2(DWELL + 1);
    localparam logic [CNT_W-1:0] DWELL_LAST  = CNT_W'(DWELL - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);
    localparam logic [CNT_W-1:0] SETTLE_C    = CNT_W'(SETTLE);

    typedef struct packed {
        spt_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [TAP_W-1:0] master;
        logic [TAP_W-1:0] slave;
        logic             sel;
        logic             hi_bad;
        logic             lo_bad;
    } spt_regs_t;

    spt_regs_t r_q, r_d;

    logic [TAP_W-1:0] probe_hi, probe_lo, step_tap;
    logic             words_differ, step_move, compare_now, active;

    spt_probe_calc #(
        .TAP_W(TAP_W), .MAX_TAP(MAX_TAP), .PROBE_OFS(PROBE_OFS)
    ) u_probe (
        .center(r_q.master), .probe_hi(probe_hi), .probe_lo(probe_lo)
    );

    spt_word_cmp #(.WORD_W(WORD_W)) u_cmp (
        .word_a(master_word), .word_b(slave_word), .differ(words_differ)
    );

    spt_step_decide #(.TAP_W(TAP_W), .MAX_TAP(MAX_TAP)) u_step (
        .center(r_q.master), .hi_bad(r_q.hi_bad), .lo_bad(r_q.lo_bad),
        .move(step_move), .next_tap(step_tap)
    );

    assign compare_now = (r_q.cnt >= SETTLE_C);
    assign active      = (r_q.state != ST_IDLE);

    always_comb begin
        r_d = r_q;
        if (!(align_done && track_en)) begin
            r_d.state  = ST_IDLE;
            r_d.cnt    = '0;
            r_d.sel    = 1'b0;
            r_d.hi_bad = 1'b0;
            r_d.lo_bad = 1'b0;
            if (!align_done) begin
                r_d.master = init_tap;
            end
            r_d.slave = r_d.master;
        end else if (!halt) begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.state  = ST_PROBE_HI;
                    r_d.slave  = probe_hi;
                    r_d.cnt    = '0;
                    r_d.hi_bad = 1'b0;
                    r_d.lo_bad = 1'b0;
                end
                ST_PROBE_HI: begin
                    if (compare_now && words_differ) r_d.hi_bad = 1'b1;
                    if (r_q.cnt == DWELL_LAST) begin
                        r_d.state = ST_PROBE_LO;
                        r_d.slave = probe_lo;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_PROBE_LO: begin
                    if (compare_now && words_differ) r_d.lo_bad = 1'b1;
                    if (r_q.cnt == DWELL_LAST) begin
                        r_d.state = ST_DECIDE;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    r_d.cnt = '0;
                    if (step_move) begin
                        r_d.state = ST_ALIGN;
                        r_d.slave = r_q.master;
                    end else begin
                        r_d.state  = ST_PROBE_HI;
                        r_d.slave  = probe_hi;
                        r_d.hi_bad = 1'b0;
                        r_d.lo_bad = 1'b0;
                    end
                end
                ST_ALIGN: begin
                    if (r_q.cnt == SETTLE_LAST) begin
                        r_d.state = ST_STEP;
                        r_d.sel   = 1'b1;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_STEP: begin
                    r_d.master = step_tap;
                    r_d.state  = ST_HOLD;
                    r_d.cnt    = '0;
                end
                ST_HOLD: begin
                    if (r_q.cnt == SETTLE_LAST) begin
                        r_d.state  = ST_PROBE_HI;
                        r_d.sel    = 1'b0;
                        r_d.slave  = probe_hi;
                        r_d.cnt    = '0;
                        r_d.hi_bad = 1'b0;
                        r_d.lo_bad = 1'b0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.cnt    <= '0;
            r_q.master <= '0;
            r_q.slave  <= '0;
            r_q.sel    <= 1'b0;
            r_q.hi_bad <= 1'b0;
            r_q.lo_bad <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign master_tap = r_q.master;
    assign slave_tap  = r_q.slave;
    assign out_sel    = r_q.sel;
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int TAP_W   = 5,
    parameter int MAX_TAP = 31
) (
    input logic             clk,
    input logic             rst_n,
    input logic             track_en,
    input logic             halt,
    input logic             align_done,
    input logic             active,
    input logic [TAP_W-1:0] master_tap,
    input logic [TAP_W-1:0] slave_tap,
    input logic             out_sel
);
    a_r1_parked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !(align_done && track_en) |=> (!out_sel && slave_tap == master_tap));

    a_r5_step_under_slave: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && master_tap != $past(master_tap))
            |-> (out_sel && $past(out_sel)));

    a_r5_slave_meets_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_sel) |-> (slave_tap == master_tap));

    a_r6_single_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && master_tap != $past(master_tap))
            |-> ((TAP_W+1)'(master_tap) == (TAP_W+1)'($past(master_tap)) + 1'b1
              || (TAP_W+1)'(master_tap) + 1'b1 == (TAP_W+1)'($past(master_tap))));

    a_r7_taps_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(master_tap) <= MAX_TAP && int'(slave_tap) <= MAX_TAP));

    a_r8_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt && align_done && track_en)
            |-> ($stable(master_tap) && $stable(slave_tap) && $stable(out_sel)));
endmodule

bind sample_point_tracker spt_checker #(
    .TAP_W(TAP_W), .MAX_TAP(MAX_TAP)
) u_spt_checker (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .halt(halt),
    .align_done(align_done), .active(active), .master_tap(master_tap),
    .slave_tap(slave_tap), .out_sel(out_sel)
);

// File: tb/sample_point_tracker_bench.sv
`timescale 1ns/1ps
module sample_point_tracker_bench;
    localparam int WORD_W = 4, TAP_W = 5, MAX_TAP = 31, OFS = 2;
    localparam int TEST_LEN = 8, SETTLE = 2;
    localparam int DWELL = SETTLE + TEST_LEN;
    localparam int PERIOD_PLAIN = 2 * DWELL + 1;
    localparam int ROUND_MAX = PERIOD_PLAIN + 2 * SETTLE + 1;
    localparam int RUN_CYC = 20 * ROUND_MAX;

    logic clk = 1'b0, rst_n = 1'b0;
    logic track_en = 1'b0, halt = 1'b0, align_done = 1'b0;
    logic [TAP_W-1:0] init_tap = '0;
    logic [WORD_W-1:0] dat = 4'b1010;
    logic [WORD_W-1:0] master_word, slave_word;
    logic [TAP_W-1:0] master_tap, slave_tap;
    logic out_sel;

    int eye_lo = 10, eye_hi = 20;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) dat <= ~dat;

    function automatic bit in_eye(int t);
        return (t >= eye_lo) && (t <= eye_hi);
    endfunction

    assign master_word = in_eye(int'(master_tap)) ? dat : ~dat;
    assign slave_word  = in_eye(int'(slave_tap))  ? dat : ~dat;

    sample_point_tracker #(
        .WORD_W(WORD_W), .TAP_W(TAP_W), .MAX_TAP(MAX_TAP), .PROBE_OFS(OFS),
        .TEST_LEN(TEST_LEN), .SETTLE(SETTLE)
    ) u_sample_point_tracker (
        .clk(clk), .rst_n(rst_n), .track_en(track_en), .halt(halt),
        .align_done(align_done), .init_tap(init_tap),
        .master_word(master_word), .slave_word(slave_word),
        .master_tap(master_tap), .slave_tap(slave_tap), .out_sel(out_sel)
    );

    function automatic int clamp_hi(int m);
        return (m + OFS > MAX_TAP) ? MAX_TAP : m + OFS;
    endfunction
    function automatic int clamp_lo(int m);
        return (m < OFS) ? 0 : m - OFS;
    endfunction
    function automatic int model_round(int m);
        bit hi_ok, lo_ok;
        hi_ok = in_eye(clamp_hi(m)) == in_eye(m);
        lo_ok = in_eye(clamp_lo(m)) == in_eye(m);
        if (hi_ok && !lo_ok && m < MAX_TAP) return m + 1;
        if (lo_ok && !hi_ok && m > 0) return m - 1;
        return m;
    endfunction
    function automatic int model_final(int m0);
        int m = m0;
        for (int k = 0; k < 64; k++) m = model_round(m);
        return m;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Hand-off and probe monitor (R5, R6, R2, R7)
    int  prev_m = 0, prev_s = 0;
    bit  prev_sel = 1'b0, prev_en = 1'b0;
    always @(negedge clk) begin
        if (rst_n && prev_en) begin
            if (int'(master_tap) != prev_m) begin
                check("R5 select during step", int'(out_sel && prev_sel), 1);
                check("R5 slave held old tap", int'(slave_tap), prev_m);
                check("R6 step size", (int'(master_tap) - prev_m) * (int'(master_tap) - prev_m), 1);
            end
            if (int'(slave_tap) != prev_s && int'(slave_tap) != int'(master_tap)) begin
                check("R2 R7 probe position",
                      int'(int'(slave_tap) == clamp_hi(int'(master_tap)) ||
                           int'(slave_tap) == clamp_lo(int'(master_tap))), 1);
            end
        end
        prev_m   = int'(master_tap);
        prev_s   = int'(slave_tap);
        prev_sel = out_sel;
        prev_en  = align_done && track_en;
    end

    task automatic run_case(int lo, int hi, int start, string tag);
        int exp;
        align_done = 1'b0;
        eye_lo = lo; eye_hi = hi;
        init_tap = TAP_W'(start);
        tick(3);
        check("R1 load while not aligned", int'(master_tap), start);
        align_done = 1'b1;
        tick(RUN_CYC);
        exp = model_final(start);
        check(tag, int'(master_tap), exp);
        check("R5 select back on primary", int'(out_sel), 0);
    endtask

    initial begin
        int t0, period;
        tick(4);
        check("R1 reset master", int'(master_tap), 0);
        check("R1 reset select", int'(out_sel), 0);
        rst_n = 1'b1;
        track_en = 1'b1;

        // R3 R6: sweep every start tap against eye 10..20
        for (int s = 0; s <= MAX_TAP; s++) run_case(10, 20, s, "R3 R6 final tap");
        // R4: both probes fail on a one-tap eye, both pass inside a wide eye
        run_case(12, 12, 12, "R4 both fail hold");
        run_case(5, 25, 15, "R4 both pass hold");
        // R7: saturation at both ends
        run_case(0, 1, 0, "R7 low saturate");
        run_case(30, 31, 31, "R7 high saturate");

        // R9: period of a round without move at tap 15 of eye 5..25
        align_done = 1'b0; eye_lo = 5; eye_hi = 25; init_tap = 5'd15;
        tick(3);
        align_done = 1'b1;
        while (int'(slave_tap) != 17) tick(1);
        while (int'(slave_tap) == 17) tick(1);
        check("R2 lower probe", int'(slave_tap), 13);
        while (int'(slave_tap) != 17) tick(1);
        t0 = $time;
        while (int'(slave_tap) == 17) tick(1);
        while (int'(slave_tap) != 17) tick(1);
        period = (int'($time) - t0) / 20;
        check("R9 round period", period, PERIOD_PLAIN);

        // R8: halt before tracking opens on an eye that needs a move
        align_done = 1'b0; eye_lo = 10; eye_hi = 20; init_tap = 5'd10;
        halt = 1'b1;
        tick(3);
        align_done = 1'b1;
        tick(300);
        check("R8 master frozen", int'(master_tap), 10);
        check("R8 slave frozen", int'(slave_tap), 10);
        halt = 1'b0;
        tick(RUN_CYC);
        check("R8 resumes after halt", int'(master_tap), model_final(10));

        // R1: tracking disabled, aligned: master holds and ignores init_tap
        align_done = 1'b0; track_en = 1'b0; init_tap = 5'd10;
        tick(3);
        align_done = 1'b1; init_tap = 5'd3;
        tick(300);
        check("R1 disabled hold", int'(master_tap), 10);
        check("R1 disabled slave parked", int'(slave_tap), 10);
        check("R1 disabled select", int'(out_sel), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule